// File: doc/BRIEF.md
# Prefetching Output Stage for a Read-Clock FIFO

This stage sits between the read port of a conventional FIFO memory and the consumer. All of its logic runs in the read clock domain. The consumer does not have to ask for data. Whenever the stage's single output slot is free and the memory reports that it holds something, the stage pulls the oldest word out of the memory and presents it on its data outputs. An active-low ready flag marks that word as present.

The consumer takes a word by holding the active-low read enable low across a rising clock edge while the ready flag is low. Such an edge is a true read. The presented word is the consumer's back-pressure point: it stays on the outputs, unchanged, for as long as the consumer leaves the read enable high. When the memory still holds data, a true read fetches the replacement in the same cycle, so words can stream out one per clock.

When the final stored word is read, the flag rises and that word is still shown on the outputs. While the flag is high, a low read enable has no effect. The output slot is storage in its own right, so a FIFO built with this stage holds one word more than its memory.

Top module: `fwft_out_stage`

## Requirements
- R1: While `rst_n` is low, `out_ready_n` is 1, `dout` is all zeros and `mem_rd` is 0, whatever the memory reports.
- R2: When the slot is empty (`out_ready_n` = 1) and `mem_empty` = 0, `mem_rd` is 1 in that cycle. After the next rising edge, `dout` equals the `mem_rdata` value of that cycle and `out_ready_n` is 0.
- R3: A true read (`out_ready_n` = 0 and `rd_en_n` = 0 at a rising edge) with `mem_empty` = 0 asserts `mem_rd` in the same cycle. The next word then appears after that edge, and `out_ready_n` stays 0.
- R4: Once the last stored word has moved to the outputs, `out_ready_n` stays 0 for as long as no true read happens.
- R5: A true read while `mem_empty` = 1 sets `out_ready_n` to 1 after the edge. `dout` keeps the word that was just read.
- R6: While `out_ready_n` = 1, `rd_en_n` = 0 has no effect: `dout` does not change and no extra memory read is issued.
- R7: While `out_ready_n` = 0 and `rd_en_n` = 1, `dout` and `out_ready_n` hold their values.
- R8: `mem_rd` is never 1 while `mem_empty` = 1.
- R9: With the consumer idle, the stage takes exactly one word from the memory and then stops issuing reads.
- R10: Words leave on `dout` in the order in which the memory supplies them, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_empty | input | 1 | Memory holds no word (1 = empty) |
| mem_rd | output | 1 | Read strobe to memory; pops the head word at the rising edge |
| mem_rdata | input | DW | Head word of memory, valid whenever `mem_empty` = 0 |
| rd_en_n | input | 1 | Consumer read enable, active low |
| dout | output | DW | Presented word |
| out_ready_n | output | 1 | Low while `dout` carries a valid, unread word |

## Verification
Several cycle-local rules are checked by the assertions on every clock:
- the strobe never fires into an empty memory;
- a fetched word appears on the next edge;
- a held word stays stable;
- a true read against an empty memory raises the flag;
- reads attempted while the flag is high change nothing;
- a true read with data behind it always refetches.

Only the bench's scenarios can show the properties that depend on a history of cycles. These are word ordering across a long mixed stream, exactly one fetch while the consumer idles, and the flag staying low after the memory drains. The bench's reference queue establishes these.

// File: rtl/fwft_pkg.sv
package fwft_pkg;
  // Occupancy of the single output slot
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_e;
endpackage

// File: rtl/fwft_fetch_ctl.sv
module fwft_fetch_ctl
  import fwft_pkg::*;
(
  input  logic  rst_n,
  input  logic  mem_empty,
  input  slot_e slot,
  input  logic  rd_en_n,
  output logic  fetch,
  output logic  take
);
  // A true read needs a presented word; a low enable on an empty slot is ignored
  always_comb begin
    take  = (slot == SLOT_FULL) && !rd_en_n;
    fetch = rst_n && !mem_empty && ((slot == SLOT_EMPTY) || take);
  end
endmodule

// File: rtl/fwft_out_reg.sv
module fwft_out_reg
  import fwft_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output slot_e         slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      slot <= SLOT_EMPTY;
    end else if (load) begin
      dout <= din;
      slot <= SLOT_FULL;
    end else if (take) begin
      // word stays visible after its read
      slot <= SLOT_EMPTY;
    end
  end
endmodule

// File: rtl/fwft_out_stage.sv
module fwft_out_stage
  import fwft_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_empty,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  input  logic          rd_en_n,
  output logic [DW-1:0] dout,
  output logic          out_ready_n
);
  slot_e slot;
  logic  take;

  fwft_fetch_ctl u_ctl (
    .rst_n    (rst_n),
    .mem_empty(mem_empty),
    .slot     (slot),
    .rd_en_n  (rd_en_n),
    .fetch    (mem_rd),
    .take     (take)
  );

  fwft_out_reg #(.DW(DW)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (mem_rd),
    .take (take),
    .din  (mem_rdata),
    .dout (dout),
    .slot (slot)
  );

  assign out_ready_n = (slot != SLOT_FULL);
endmodule

// File: rtl/fwft_out_stage_chk.sv
module fwft_out_stage_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_empty,
  input logic          mem_rd,
  input logic [DW-1:0] mem_rdata,
  input logic          rd_en_n,
  input logic [DW-1:0] dout,
  input logic          out_ready_n
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (out_ready_n && dout == '0 && !mem_rd)); // R1
  AST_FETCH_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!out_ready_n && dout == $past(mem_rdata))); // R2
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready_n && !rd_en_n && !mem_empty) |-> mem_rd); // R3
  AST_DRAIN_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready_n && !rd_en_n && mem_empty) |=> (out_ready_n && $stable(dout))); // R5
  AST_IDLE_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready_n && !mem_rd) |=> (out_ready_n && $stable(dout))); // R6
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready_n && rd_en_n) |=> (!out_ready_n && $stable(dout))); // R7
  AST_NO_EMPTY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !mem_empty); // R8
  AST_SINGLE_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready_n && rd_en_n) |-> !mem_rd); // R9
endmodule

bind fwft_out_stage fwft_out_stage_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_empty(mem_empty), .mem_rd(mem_rd),
  .mem_rdata(mem_rdata), .rd_en_n(rd_en_n), .dout(dout), .out_ready_n(out_ready_n)
);

// File: tb/sim_fwft_out_stage.sv
`timescale 1ns/1ps
module sim_fwft_out_stage;
  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_empty;
  logic          mem_rd;
  logic [DW-1:0] mem_rdata;
  logic          rd_en_n = 1'b1;
  logic [DW-1:0] dout;
  logic          out_ready_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference: memory contents, slot state, and every word accepted by the consumer
  logic [DW-1:0] memq[$];
  logic [DW-1:0] sent[$];
  logic [DW-1:0] got[$];
  bit            m_full = 0;
  logic [DW-1:0] m_data = '0;
  string         tag = "R1";

  always #5 clk = ~clk;

  fwft_out_stage #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_empty(mem_empty), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .rd_en_n(rd_en_n), .dout(dout), .out_ready_n(out_ready_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_mem();
    mem_empty = (memq.size() == 0);
    mem_rdata = (memq.size() != 0) ? memq[0] : '0;
  endtask

  task automatic push(logic [DW-1:0] w);
    memq.push_back(w);
    sent.push_back(w);
  endtask

  // one clock: drive at negedge, check strobe, advance model, check outputs
  task automatic step(bit rd);
    bit exp_rd, tread;
    rd_en_n = ~rd;
    drive_mem();
    #1;
    tread  = rst_n && m_full && rd;
    exp_rd = rst_n && (memq.size() != 0) && (!m_full || tread);
    check(tag, mem_rd, exp_rd, "mem_rd");
    @(posedge clk);
    if (tread) got.push_back(m_data);
    if (exp_rd) begin
      m_data = memq.pop_front();
      m_full = 1;
    end else if (tread) begin
      m_full = 0;
    end
    @(negedge clk);
    check(tag, out_ready_n, !m_full, "out_ready_n");
    check(tag, dout, m_data, "dout");
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    drive_mem();
    @(negedge clk);
    // R1: reset state with data waiting in memory
    tag = "R1";
    push(9'h1A5);
    drive_mem();
    #1;
    check("R1", mem_rd, 0, "mem_rd in reset");
    check("R1", out_ready_n, 1, "out_ready_n in reset");
    check("R1", dout, 0, "dout in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R2: prefetch without request
    tag = "R2";
    step(0);
    check("R2", dout, 9'h1A5, "prefetched word");
    // R9 / R7: idle consumer, more data behind, exactly one word taken
    push(9'h033); push(9'h044);
    tag = "R9";
    for (int i = 0; i < 6; i++) step(0);
    check("R9", memq.size(), 2, "memory words left");
    check("R7", dout, 9'h1A5, "held word");
    // R3 / R10: stream back-to-back
    tag = "R3";
    step(1); step(1);
    // R4: last word presented, flag stays low
    tag = "R4";
    for (int i = 0; i < 4; i++) step(0);
    check("R4", out_ready_n, 0, "flag after drain");
    // R5: read of the final word
    tag = "R5";
    step(1);
    check("R5", out_ready_n, 1, "flag after last read");
    check("R5", dout, 9'h044, "last word kept");
    // R6: reads against empty slot ignored
    tag = "R6";
    for (int i = 0; i < 4; i++) step(1);
    check("R6", dout, 9'h044, "dout after ignored reads");
    // R10: mixed random traffic
    tag = "R10";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0] && memq.size() < 8) push(DW'(lfsr[11:3]));
      step(lfsr[5] | lfsr[6]);
    end
    while (memq.size() != 0 || m_full) step(1);
    check("R10", got.size(), sent.size(), "words delivered");
    for (int i = 0; i < got.size() && i < sent.size(); i++)
      check("R10", got[i], sent[i], "word order");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule